// File: doc/BRIEF.md
# SPI Port with Mode-Fault Detection

This block is one SPI port that runs either as the clock-driving end (master) or as a selected follower (slave). It moves one byte per transfer, full duplex and most significant bit first. A small control register holds the enable, master select, clock polarity and phase, a two-bit rate code and a flag that turns the select pin into a plain output. In master mode the block divides the system clock to make SCK. In slave mode it follows an external SCK while the select input is low. Its pins are brought out as separate input, output and output-enable signals, so the pad cells stay outside the block.

A master whose select input is pulled low by another device raises a mode-fault flag. At the same time it drops out of master mode and out of enable, releases SCK and MOSI, and abandons any byte in flight. Setting the select-as-output flag turns this check off and drives the select pin from a level input instead. Received bytes land in a read-only register at the moment the eighth bit is sampled, and a completion flag is raised in the same cycle.

Top module: `spi_port`

## Requirements
- R1: A transfer exchanges one byte MSB first: the byte written on `tx_data_i` leaves on the data output while eight bits are taken from the data input, and `rx_data_o` holds the eight received bits once the byte ends.
- R2: While no byte is in flight, `sck_o` rests at the CPOL level. With CPHA=0 the first bit is on the line before the first edge and bits are sampled on leading edges (away from the rest level). With CPHA=1 bits are sampled on trailing edges. Each bit is driven half an SCK period before the edge that samples it.
- R3: In master mode a rate code of 0, 1, 2 or 3 gives an SCK period of 2, 4, 16 or 32 system clocks.
- R4: In slave mode the rate code has no effect on the transfer.
- R5: `miso_oe_o` is high only when the port is enabled, in slave mode and `ss_ni` is low. It is low in every other case.
- R6: If the slave select rises before the eighth bit, the partial byte is discarded: no completion is flagged, `busy_o` drops, and the next byte starts counting from its first bit.
- R7: When an enabled master with select-as-output clear sees `ss_ni` low, `modf_o` rises on the third rising clock edge after the pin change. On that same edge `en_o`, `mstr_o`, `sck_oe_o`, `mosi_oe_o` and `busy_o` go low.
- R8: `modf_o` stays high until a `modf_clr_i` pulse clears it.
- R9: With select-as-output set, `ss_oe_o` is high, `ss_o` follows `ss_level_i`, and a low `ss_ni` raises no mode fault.
- R10: `done_o` and `rx_data_o` update on the same edge that takes the eighth sample. `done_o` is cleared by `done_clr_i` or by a new `tx_we_i`.
- R11: After reset the port is disabled, nothing is driven, and the flags and the receive register are zero.
- R12: Slave-side SCK, MOSI and select pass through two synchronizer flops. The slave acts on a pin change at the third rising clock edge after it, so the system clock must run at least four times the SCK rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Write strobe for the control fields below |
| cfg_en_i | input | 1 | Port enable |
| cfg_mstr_i | input | 1 | 1 = master, 0 = slave |
| cfg_cpol_i | input | 1 | SCK rest level |
| cfg_cpha_i | input | 1 | 0 = sample on leading edge, 1 = on trailing edge |
| cfg_rate_i | input | 2 | Master SCK rate code |
| cfg_ss_out_i | input | 1 | Select pin as plain output; disables mode-fault check |
| tx_we_i | input | 1 | Load transmit byte; starts a transfer in master mode |
| tx_data_i | input | DATA_W | Transmit byte |
| done_clr_i | input | 1 | Clear completion flag |
| modf_clr_i | input | 1 | Clear mode-fault flag |
| ss_level_i | input | 1 | Level driven on the select pin when it is an output |
| en_o | output | 1 | Current enable bit |
| mstr_o | output | 1 | Current master bit |
| busy_o | output | 1 | Byte in flight |
| done_o | output | 1 | Completion flag |
| modf_o | output | 1 | Mode-fault flag |
| rx_data_o | output | DATA_W | Last received byte |
| sck_i | input | 1 | SCK pin input (slave) |
| sck_o | output | 1 | SCK pin output (master) |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_i | input | 1 | MOSI pin input (slave) |
| mosi_o | output | 1 | MOSI pin output (master) |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | MISO pin input (master) |
| miso_o | output | 1 | MISO pin output (slave) |
| miso_oe_o | output | 1 | MISO output enable |
| ss_ni | input | 1 | Select pin input, active low |
| ss_o | output | 1 | Select pin output value |
| ss_oe_o | output | 1 | Select pin output enable |

## Verification
Master results follow the divider directly. SCK toggles every 1, 2, 8 or 16 clocks after the start edge, so the bench times the gap between two toggles it sees. It samples MOSI on the sampling toggle and changes MISO one clock after each shifting toggle, a full half period before the master samples it. Slave and mode-fault results come three rising edges after the pin change, because of the two synchronizer flops and the edge register. The bench checks `done_o` low two clocks after the eighth sampling edge and high on the third, and checks `modf_o` the same way after select falls. MISO output enable is combinational in the select pin and is checked at the very next falling clock edge.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int unsigned HALF_R0  = 1;
  localparam int unsigned HALF_R1  = 2;
  localparam int unsigned HALF_R2  = 8;
  localparam int unsigned HALF_R3  = 16;
  localparam int unsigned HALF_MAX = 16;
  localparam int unsigned DIV_W    = $clog2(HALF_MAX);

  typedef struct packed {
    logic       en;
    logic       mstr;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
    logic       ss_out;
  } spi_cfg_t;

  // system clocks per SCK half period, minus one
  function automatic logic [DIV_W-1:0] half_lim(input logic [1:0] code);
    case (code)
      2'd0:    return DIV_W'(HALF_R0 - 1);
      2'd1:    return DIV_W'(HALF_R1 - 1);
      2'd2:    return DIV_W'(HALF_R2 - 1);
      default: return DIV_W'(HALF_R3 - 1);
    endcase
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    logic [W-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= RST_VAL;
        else         q <= g_stg[s-1].q;
    end
  end
  assign q_o = g_stg[STAGES-1].q;
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen
  import spi_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign lim    = half_lim(rate_i);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              mstr_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              abort_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tick_i,
  input  logic              miso_i,
  input  logic              s_sck_i,
  input  logic              s_mosi_i,
  input  logic              s_ss_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              sck_o,
  output logic              out_bit_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  localparam int unsigned KW = $clog2(2 * DATA_W);
  localparam int unsigned BW = $clog2(DATA_W);
  localparam logic [KW-1:0] K_LAST = KW'(2 * DATA_W - 1);
  localparam logic [BW-1:0] B_LAST = BW'(DATA_W - 1);

  logic              run_q, sck_q, out_q, s_sck_q;
  logic [KW-1:0]     k_q;
  logic [BW-1:0]     bcnt_q;
  logic [DATA_W-1:0] sr_q, rx_q;

  logic slv, m_samp, m_shft, s_edge, s_away, s_samp, s_shft;
  logic samp, shft, in_bit, last, start;

  assign slv    = en_i && !mstr_i;
  assign m_samp = run_q && tick_i && (k_q[0] == cpha_i);
  assign m_shft = run_q && tick_i && (k_q[0] != cpha_i);
  assign s_edge = slv && !s_ss_i && (s_sck_i != s_sck_q);
  assign s_away = s_sck_i != cpol_i;   // edge leaving the rest level
  assign s_samp = s_edge && (s_away != cpha_i);
  assign s_shft = s_edge && (s_away == cpha_i);
  assign samp   = m_samp || s_samp;
  assign shft   = m_shft || s_shft;
  assign in_bit = run_q ? miso_i : s_mosi_i;
  assign last   = bcnt_q == B_LAST;
  assign start  = tx_we_i && en_i && mstr_i && !run_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) s_sck_q <= 1'b0;
    else         s_sck_q <= s_sck_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      sck_q  <= 1'b0;
      out_q  <= 1'b0;
      k_q    <= '0;
      bcnt_q <= '0;
      sr_q   <= '0;
      rx_q   <= '0;
    end else if (abort_i || !en_i) begin
      run_q  <= 1'b0;
      sck_q  <= cpol_i;
      k_q    <= '0;
      bcnt_q <= '0;
    end else begin
      if (!run_q) sck_q <= cpol_i;
      if (slv && s_ss_i) bcnt_q <= '0;  // deselect drops a partial byte
      if (start) begin
        run_q  <= 1'b1;
        k_q    <= '0;
        bcnt_q <= '0;
        sr_q   <= tx_data_i;
        out_q  <= tx_data_i[DATA_W-1];
      end else if (slv && tx_we_i && bcnt_q == '0) begin
        sr_q  <= tx_data_i;
        out_q <= tx_data_i[DATA_W-1];
      end
      if (run_q && tick_i) begin
        sck_q <= !sck_q;
        k_q   <= k_q + 1'b1;
        if (k_q == K_LAST) run_q <= 1'b0;
      end
      if (samp) begin
        sr_q   <= {sr_q[DATA_W-2:0], in_bit};
        bcnt_q <= last ? '0 : bcnt_q + 1'b1;
        if (last) rx_q <= {sr_q[DATA_W-2:0], in_bit};
      end
      if (shft) out_q <= sr_q[DATA_W-1];
    end
  end

  assign run_o      = run_q;
  assign busy_o     = run_q || (bcnt_q != '0);
  assign sck_o      = sck_q;
  assign out_bit_o  = out_q;
  assign rx_data_o  = rx_q;
  assign rx_valid_o = samp && last;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_en_i,
  input  logic              cfg_mstr_i,
  input  logic              cfg_cpol_i,
  input  logic              cfg_cpha_i,
  input  logic [1:0]        cfg_rate_i,
  input  logic              cfg_ss_out_i,
  input  logic              tx_we_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              done_clr_i,
  input  logic              modf_clr_i,
  input  logic              ss_level_i,
  output logic              en_o,
  output logic              mstr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              modf_o,
  output logic [DATA_W-1:0] rx_data_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic              ss_ni,
  output logic              ss_o,
  output logic              ss_oe_o
);
  spi_cfg_t cfg_q;
  logic     modf_q, done_q, modf_set;
  logic     s_ss, s_sck, s_mosi;
  logic     run, tick, sck_int, out_bit, rx_valid;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, sck_i, mosi_i}),
    .q_o   ({s_ss, s_sck, s_mosi})
  );

  assign modf_set = cfg_q.en && cfg_q.mstr && !cfg_q.ss_out && !s_ss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      modf_q <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        cfg_q.en     <= cfg_en_i;
        cfg_q.mstr   <= cfg_mstr_i;
        cfg_q.cpol   <= cfg_cpol_i;
        cfg_q.cpha   <= cfg_cpha_i;
        cfg_q.rate   <= cfg_rate_i;
        cfg_q.ss_out <= cfg_ss_out_i;
      end
      if (modf_set) begin
        modf_q     <= 1'b1;
        cfg_q.en   <= 1'b0;
        cfg_q.mstr <= 1'b0;
      end else if (modf_clr_i) begin
        modf_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    done_q <= 1'b0;
    else if (rx_valid)              done_q <= 1'b1;
    else if (done_clr_i || tx_we_i) done_q <= 1'b0;

  spi_clkgen u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .rate_i(cfg_q.rate),
    .tick_o(tick)
  );

  spi_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (cfg_q.en),
    .mstr_i    (cfg_q.mstr),
    .cpol_i    (cfg_q.cpol),
    .cpha_i    (cfg_q.cpha),
    .abort_i   (modf_set),
    .tx_we_i   (tx_we_i),
    .tx_data_i (tx_data_i),
    .tick_i    (tick),
    .miso_i    (miso_i),
    .s_sck_i   (s_sck),
    .s_mosi_i  (s_mosi),
    .s_ss_i    (s_ss),
    .run_o     (run),
    .busy_o    (busy_o),
    .sck_o     (sck_int),
    .out_bit_o (out_bit),
    .rx_data_o (rx_data_o),
    .rx_valid_o(rx_valid)
  );

  assign en_o      = cfg_q.en;
  assign mstr_o    = cfg_q.mstr;
  assign done_o    = done_q;
  assign modf_o    = modf_q;
  assign sck_o     = sck_int;
  assign sck_oe_o  = cfg_q.en && cfg_q.mstr;
  assign mosi_o    = out_bit;
  assign mosi_oe_o = cfg_q.en && cfg_q.mstr;
  assign miso_o    = out_bit;
  assign miso_oe_o = cfg_q.en && !cfg_q.mstr && !ss_ni;
  assign ss_o      = ss_level_i;
  assign ss_oe_o   = cfg_q.ss_out;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cpol_i,
  input logic busy_i,
  input logic sck_i,
  input logic done_i,
  input logic modf_i,
  input logic modf_clr_i,
  input logic en_i,
  input logic mstr_i,
  input logic sck_oe_i,
  input logic ss_oe_i
);
  AST_SCK_REST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !$past(busy_i) && $stable(cpol_i)) |-> (sck_i == cpol_i)); // R2

  AST_DONE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> $past(busy_i)); // R1

  AST_MODF_SHUTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modf_i) |-> (!en_i && !mstr_i && !sck_oe_i && !busy_i)); // R7

  AST_MODF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modf_i && !modf_clr_i) |=> modf_i); // R8

  AST_SS_OUT_NO_MODF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ss_oe_i) |-> !$rose(modf_i)); // R9
endmodule

bind spi_port spi_port_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cpol_i    (cfg_q.cpol),
  .busy_i    (busy_o),
  .sck_i     (sck_o),
  .done_i    (done_o),
  .modf_i    (modf_o),
  .modf_clr_i(modf_clr_i),
  .en_i      (en_o),
  .mstr_i    (mstr_o),
  .sck_oe_i  (sck_oe_o),
  .ss_oe_i   (ss_oe_o)
);

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
  localparam int SH = 8;  // slave-side SCK half period in system clocks

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 0, cfg_en_i = 0, cfg_mstr_i = 0, cfg_cpol_i = 0, cfg_cpha_i = 0;
  logic [1:0] cfg_rate_i = 0;
  logic cfg_ss_out_i = 0, tx_we_i = 0, done_clr_i = 0, modf_clr_i = 0, ss_level_i = 0;
  logic [7:0] tx_data_i = 0;
  logic sck_i = 0, mosi_i = 0, miso_i = 0, ss_ni = 1;
  logic en_o, mstr_o, busy_o, done_o, modf_o;
  logic [7:0] rx_data_o;
  logic sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o, ss_o, ss_oe_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_en_i(cfg_en_i), .cfg_mstr_i(cfg_mstr_i),
    .cfg_cpol_i(cfg_cpol_i), .cfg_cpha_i(cfg_cpha_i), .cfg_rate_i(cfg_rate_i),
    .cfg_ss_out_i(cfg_ss_out_i), .tx_we_i(tx_we_i), .tx_data_i(tx_data_i),
    .done_clr_i(done_clr_i), .modf_clr_i(modf_clr_i), .ss_level_i(ss_level_i),
    .en_o(en_o), .mstr_o(mstr_o), .busy_o(busy_o), .done_o(done_o), .modf_o(modf_o),
    .rx_data_o(rx_data_o), .sck_i(sck_i), .sck_o(sck_o), .sck_oe_o(sck_oe_o),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_i),
    .miso_o(miso_o), .miso_oe_o(miso_oe_o), .ss_ni(ss_ni), .ss_o(ss_o), .ss_oe_o(ss_oe_o)
  );

  // {cpol, cpha, rate, tx byte, byte returned on MISO}
  localparam logic [19:0] MVEC [8] = '{
    {1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 2'd1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 2'd2, 8'h5A, 8'hC3},
    {1'b1, 1'b1, 2'd3, 8'hF0, 8'h0F},
    {1'b0, 1'b0, 2'd3, 8'h01, 8'h80},
    {1'b1, 1'b1, 2'd0, 8'hFF, 8'h00},
    {1'b0, 1'b1, 2'd2, 8'h96, 8'h69},
    {1'b1, 1'b0, 2'd1, 8'h00, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input logic en, mstr, cpol, cpha, input logic [1:0] rate, input logic sso);
    cfg_en_i = en; cfg_mstr_i = mstr; cfg_cpol_i = cpol; cfg_cpha_i = cpha;
    cfg_rate_i = rate; cfg_ss_out_i = sso; cfg_we_i = 1;
    @(negedge clk); cfg_we_i = 0;
  endtask

  task automatic write_tx(input logic [7:0] b);
    tx_data_i = b; tx_we_i = 1;
    @(negedge clk); tx_we_i = 0;
  endtask

  task automatic master_xfer(input logic cpol, cpha, input logic [1:0] rate,
                             input logic [7:0] tx, mi);
    logic prev;
    logic [7:0] mb;
    int e, gap, half, bitp, wd, exp_half;
    case (rate)
      2'd0: exp_half = 1;
      2'd1: exp_half = 2;
      2'd2: exp_half = 8;
      default: exp_half = 16;
    endcase
    cfg(1, 1, cpol, cpha, rate, 0);
    @(negedge clk);
    check("R2 sck rest level", sck_o, cpol);
    miso_i = mi[7];
    write_tx(tx);
    prev = sck_o; e = 0; gap = 0; half = 0; mb = 0; wd = 0;
    bitp = cpha ? 7 : 6;
    while (e < 16 && wd < 2000) begin
      @(negedge clk); wd++; gap++;
      if (sck_o !== prev) begin
        prev = sck_o;
        if (e == 1) half = gap;
        gap = 0;
        if (((e % 2) == 0) == (cpha == 1'b0)) mb = {mb[6:0], mosi_o};
        else begin
          if (bitp >= 0) miso_i = mi[bitp];
          bitp--;
        end
        e++;
      end
    end
    wait_n(2);
    check("R3 half period", half, exp_half);
    check("R1 master rx", rx_data_o, mi);
    check("R1 master tx on mosi", mb, tx);
    check("R10 done after master byte", done_o, 1);
    check("R2 sck back at rest", sck_o, cpol);
    check("R1 busy low after byte", busy_o, 0);
    done_clr_i = 1; @(negedge clk); done_clr_i = 0;
    check("R10 done cleared", done_o, 0);
  endtask

  task automatic slave_xfer(input logic cpol, cpha, input logic [1:0] rate,
                            input logic [7:0] tx, mo, input int stop_at);
    logic [7:0] mb;
    logic smp;
    int nb;
    cfg(1, 0, cpol, cpha, rate, 0);
    sck_i = cpol; ss_ni = 1;
    wait_n(4);
    write_tx(tx);
    wait_n(2);
    ss_ni = 0; mosi_i = mo[7];
    wait_n(SH);
    mb = 0;
    for (int e = 0; e < stop_at; e++) begin
      smp = ((e % 2) == 0) == (cpha == 1'b0);
      if (smp) mb = {mb[6:0], miso_o};
      sck_i = ~sck_i;
      if (!smp) begin
        nb = cpha ? 7 - e / 2 : 7 - (e + 1) / 2;
        if (nb >= 0) mosi_i = mo[nb];
      end
      if (smp && e / 2 == 7) begin
        wait_n(2);
        check("R12 done not before third edge", done_o, 0);
        wait_n(1);
        check("R10 R12 done on third edge", done_o, 1);
        check("R10 slave rx", rx_data_o, mo);
        wait_n(SH - 3);
      end else wait_n(SH);
    end
    if (stop_at == 16) check("R1 slave tx on miso", mb, tx);
    ss_ni = 1;
    wait_n(4);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    check("R11 reset en", en_o, 0);
    check("R11 reset modf", modf_o, 0);
    check("R11 reset done", done_o, 0);
    check("R11 reset rx", rx_data_o, 0);
    check("R11 reset oe", {sck_oe_o, mosi_oe_o, miso_oe_o, ss_oe_o}, 0);
    rst_ni = 1;
    wait_n(2);

    foreach (MVEC[i]) begin
      logic [19:0] v;
      v = MVEC[i];
      master_xfer(v[19], v[18], v[17:16], v[15:8], v[7:0]);
    end

    // R5 MISO release
    cfg(1, 1, 0, 0, 0, 0);
    ss_ni = 0; #1;
    check("R5 master never drives miso", miso_oe_o, 0);
    ss_ni = 1;
    cfg(1, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R5 slave unselected", miso_oe_o, 0);
    ss_ni = 0; @(negedge clk);
    check("R5 slave selected", miso_oe_o, 1);
    ss_ni = 1; @(negedge clk);
    check("R5 slave released", miso_oe_o, 0);

    // slave transfers, R4 rate ignored
    slave_xfer(0, 0, 2'd0, 8'hC5, 8'h3A, 16);
    slave_xfer(0, 0, 2'd3, 8'h5C, 8'hA3, 16);
    slave_xfer(1, 1, 2'd3, 8'h81, 8'h18, 16);
    slave_xfer(0, 1, 2'd1, 8'h6E, 8'hB7, 16);
    slave_xfer(1, 0, 2'd2, 8'hE7, 8'h7E, 16);
    check("R4 rx unchanged by rate", rx_data_o, 8'h7E);

    // R6 partial byte discarded
    done_clr_i = 1; @(negedge clk); done_clr_i = 0;
    slave_xfer(0, 0, 2'd0, 8'h99, 8'h55, 8);
    wait_n(2);
    check("R6 no done after abort", done_o, 0);
    check("R6 busy low after abort", busy_o, 0);
    check("R6 rx kept", rx_data_o, 8'h7E);
    slave_xfer(0, 0, 2'd0, 8'h4D, 8'hD2, 16);
    check("R6 next byte aligned", rx_data_o, 8'hD2);

    // R7 R8 mode fault
    cfg(0, 0, 0, 0, 0, 0);
    cfg(1, 1, 0, 0, 2'd3, 0);
    write_tx(8'hAA);
    wait_n(20);
    check("R7 busy before fault", busy_o, 1);
    ss_ni = 0;
    wait_n(2);
    check("R7 no fault before third edge", modf_o, 0);
    wait_n(1);
    check("R7 fault flag", modf_o, 1);
    check("R7 enable cleared", en_o, 0);
    check("R7 master cleared", mstr_o, 0);
    check("R7 pins released", {sck_oe_o, mosi_oe_o}, 0);
    check("R7 transfer aborted", busy_o, 0);
    ss_ni = 1;
    wait_n(6);
    check("R8 fault held", modf_o, 1);
    modf_clr_i = 1; @(negedge clk); modf_clr_i = 0;
    check("R8 fault cleared", modf_o, 0);

    // R9 select as output
    ss_level_i = 0;
    cfg(1, 1, 0, 0, 0, 1);
    check("R9 ss driven", ss_oe_o, 1);
    check("R9 ss level low", ss_o, 0);
    ss_ni = 0;
    wait_n(6);
    check("R9 no fault", modf_o, 0);
    check("R9 still master", {en_o, mstr_o}, 2'b11);
    ss_level_i = 1; #1;
    check("R9 ss level high", ss_o, 1);
    ss_ni = 1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule